// File: doc/BRIEF.md
# Sized Add/Subtract Unit with Extend Flag

This block is the integer add and subtract datapath of a two-operand processor core. It takes a source and a destination operand and returns the destination's new value together with the five condition codes: extend, negative, zero, overflow and carry. Each code comes with a write-enable. The operand size can be byte, word or long. Four instruction forms share the same adder: register, immediate, quick and extended. The extended form also consumes the incoming extend bit, so that operands wider than 32 bits can be added or subtracted in chained steps.

The block is purely combinational. Operand fetch, address generation and the register file are outside it. A data-register destination keeps its bits above the operand size. An address-register destination takes a full 32-bit result, built from the sign-extended source, and no condition code is written for it.

Top module: `addsub_ccr_unit`

## Requirements
- R1: `size_i` selects the operand width: 00 is byte, 01 is word, and 10 or 11 is long. For a data destination (`areg_i`=0), the bits of `res_o` above the selected width equal the same bits of `dst_i`.
- R2: When `op_i[2]`=0 the low sized bits of `res_o` are (dst + src + cin) modulo 2^width. The carry out of the top sized bit is C, which is `ccr_o[0]`.
- R3: When `op_i[2]`=1 the low sized bits of `res_o` are (dst - src - cin) modulo 2^width. C is 1 when a borrow occurs, that is, when dst < src + cin taken as unsigned numbers.
- R4: V (`ccr_o[1]`) is 1 when the true signed result falls outside the two's-complement range of the selected width, and 0 otherwise. Example: byte 90+107 gives 0xC5 with V=1 and C=0.
- R5: N (`ccr_o[3]`) equals the top bit of the sized result. For non-extended forms, Z (`ccr_o[2]`) is 1 exactly when the sized result is zero.
- R6: X (`ccr_o[4]`) always equals C for a data destination. Example: byte 90-107 gives 0xEF with X=1, N=1, Z=0, V=0, C=1.
- R7: `op_i[1:0]` selects the form: 00 is register, 01 is immediate, 10 is quick and 11 is extended. cin equals `x_i` in the extended form and 0 in every other form.
- R8: In the extended form, Z is `z_i` AND (sized result == 0). A nonzero result clears Z, and a zero result leaves `z_i` unchanged.
- R9: In the quick form the source is `src_i[2:0]` taken as a value from 1 to 7, with 000 standing for 8. `src_i[31:3]` is ignored.
- R10: When `areg_i`=1 the source is sign-extended from the selected width to 32 bits. `res_o` is then `dst_i` plus or minus that value over all 32 bits, `x_i` is not used, and `ccr_we_o` is 00000.
- R11: When `areg_i`=0, `ccr_we_o` is 11111. The bit order of both `ccr_o` and `ccr_we_o` is {X,N,Z,V,C}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_i | input | 32 | Source operand; in the quick form, bits 2:0 hold the immediate field |
| dst_i | input | 32 | Destination operand |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 1x long |
| op_i | input | 3 | Bit 2 selects subtract; bits 1:0 select the form |
| x_i | input | 1 | Incoming extend flag |
| z_i | input | 1 | Incoming zero flag |
| areg_i | input | 1 | Destination is an address register |
| res_o | output | 32 | Value to write to the destination |
| ccr_o | output | 5 | New condition codes {X,N,Z,V,C} |
| ccr_we_o | output | 5 | Write-enables for ccr_o, same bit order |

## Verification
Two flag rules are the hardest to reach by chance. The first is the sticky zero flag of the extended form, which depends at once on `z_i`, on `x_i` and on a sized result of exactly zero. Random operands almost never produce that zero. The second is the borrow corner in which `x_i` turns an equal subtraction into an underflow. The stimulus therefore sets these up directly: equal operands with and without an incoming extend bit, in both polarities of `z_i` and at every size. A long random run, checked against a behavioural integer model, then covers the other cases.

// File: rtl/addsub_ccr_unit.sv
module addsub_ccr_unit (
  input  logic [31:0] src_i,
  input  logic [31:0] dst_i,
  input  logic [1:0]  size_i,
  input  logic [2:0]  op_i,
  input  logic        x_i,
  input  logic        z_i,
  input  logic        areg_i,
  output logic [31:0] res_o,
  output logic [4:0]  ccr_o,
  output logic [4:0]  ccr_we_o
);
  logic        sub, ext, quick, cin, c, v, zf;
  logic [4:0]  sh;
  logic [31:0] srcv, a, b, r, m, sres, sx, ares;
  logic [32:0] wide;

  assign sub   = op_i[2];
  assign ext   = op_i[1:0] == 2'b11;
  assign quick = op_i[1:0] == 2'b10;
  assign srcv  = quick ? {28'd0, src_i[2:0] == 3'd0, src_i[2:0]} : src_i;

  always_comb begin
    case (size_i)
      2'b00:   sh = 5'd24;
      2'b01:   sh = 5'd16;
      default: sh = 5'd0;
    endcase
  end

  assign a   = dst_i << sh;
  assign b   = srcv << sh;
  assign cin = ext & x_i & ~areg_i;

  assign wide = sub ? ({1'b0, a} - {1'b0, b} - ({32'd0, cin} << sh))
                    : ({1'b0, a} + {1'b0, b} + ({32'd0, cin} << sh));
  assign r  = wide[31:0];
  assign c  = wide[32];
  assign v  = sub ? ((a[31] ^ b[31]) & (r[31] ^ a[31]))
                  : (~(a[31] ^ b[31]) & (r[31] ^ a[31]));
  assign zf = ext ? (z_i & (r == 32'd0)) : (r == 32'd0);

  assign m    = 32'hFFFF_FFFF >> sh;
  assign sres = (dst_i & ~m) | (r >> sh);

  always_comb begin
    case (size_i)
      2'b00:   sx = {{24{srcv[7]}}, srcv[7:0]};
      2'b01:   sx = {{16{srcv[15]}}, srcv[15:0]};
      default: sx = srcv;
    endcase
  end
  assign ares = sub ? dst_i - sx : dst_i + sx;

  assign res_o    = areg_i ? ares : sres;
  assign ccr_o    = {c, r[31], zf, v, c};
  assign ccr_we_o = areg_i ? 5'b00000 : 5'b11111;
endmodule

module addsub_ccr_unit_chk (
  input logic [31:0] dst_i,
  input logic [1:0]  size_i,
  input logic [2:0]  op_i,
  input logic        z_i,
  input logic        areg_i,
  input logic [31:0] res_o,
  input logic [4:0]  ccr_o,
  input logic [4:0]  ccr_we_o
);
  logic known;
  assign known = !$isunknown({dst_i, size_i, op_i, z_i, areg_i, res_o, ccr_o, ccr_we_o});

  always_comb begin
    if (known) begin
      AST_AREG_NO_WRITE: assert (!areg_i || ccr_we_o == 5'b00000); // R10
      AST_DATA_ALL_WRITE: assert (areg_i || ccr_we_o == 5'b11111); // R11
      AST_X_FOLLOWS_C: assert (areg_i || ccr_o[4] == ccr_o[0]); // R6
      AST_BYTE_UPPER_KEPT: assert (areg_i || size_i != 2'b00 || res_o[31:8] == dst_i[31:8]); // R1
      AST_WORD_UPPER_KEPT: assert (areg_i || size_i != 2'b01 || res_o[31:16] == dst_i[31:16]); // R1
      AST_LONG_N_MSB: assert (areg_i || size_i[1] == 1'b0 || ccr_o[3] == res_o[31]); // R5
      AST_EXT_Z_STICKY: assert (areg_i || op_i[1:0] != 2'b11 || z_i || !ccr_o[2]); // R8
    end
  end
endmodule

bind addsub_ccr_unit addsub_ccr_unit_chk chk_i (
  .dst_i(dst_i), .size_i(size_i), .op_i(op_i), .z_i(z_i), .areg_i(areg_i),
  .res_o(res_o), .ccr_o(ccr_o), .ccr_we_o(ccr_we_o)
);

// File: tb/addsub_ccr_unit_tb_top.sv
module addsub_ccr_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] src, dst, res;
  logic [1:0]  size;
  logic [2:0]  op;
  logic        x, z, areg;
  logic [4:0]  ccr, we;
  int checks = 0;
  int errors = 0;

  addsub_ccr_unit dut_i (
    .src_i(src), .dst_i(dst), .size_i(size), .op_i(op), .x_i(x), .z_i(z),
    .areg_i(areg), .res_o(res), .ccr_o(ccr), .ccr_we_o(we)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model(output logic [31:0] er, output logic [4:0] ef, output logic [4:0] ewe);
    int w;
    longint mask, half, d, s, sv, full, sd, ss, ci, sxv;
    w    = (size == 2'b00) ? 8 : (size == 2'b01) ? 16 : 32;
    mask = (64'd1 << w) - 1;
    half = 64'd1 << (w - 1);
    s    = (op[1:0] == 2'b10) ? ((src[2:0] == 3'd0) ? 8 : longint'(src[2:0])) : longint'(src);
    d    = longint'(dst);
    ef   = 5'b0;
    if (areg) begin
      sxv = s & mask;
      if (sxv >= half) sxv = sxv - (64'd1 << w);
      er  = op[2] ? 32'(d - sxv) : 32'(d + sxv);
      ewe = 5'b00000;
    end else begin
      ci = (op[1:0] == 2'b11) ? longint'(x) : 0;
      d  = d & mask;
      s  = s & mask;
      sd = (d >= half) ? d - (64'd1 << w) : d;
      ss = (s >= half) ? s - (64'd1 << w) : s;
      if (op[2]) begin
        full  = d - s - ci;
        sv    = sd - ss - ci;
        ef[0] = (d < s + ci);
      end else begin
        full  = d + s + ci;
        sv    = sd + ss + ci;
        ef[0] = ((full >> w) & 1) != 0;
      end
      full  = full & mask;
      ef[1] = (sv >= half) || (sv < -half);
      ef[3] = full >= half;
      ef[2] = (full == 0) && ((op[1:0] != 2'b11) || z);
      ef[4] = ef[0];
      er    = (dst & ~32'(mask)) | 32'(full);
      ewe   = 5'b11111;
    end
  endtask

  task automatic apply(input logic [31:0] s_, input logic [31:0] d_, input logic [1:0] sz_,
                       input logic [2:0] o_, input logic x_, input logic z_, input logic a_);
    logic [31:0] er;
    logic [4:0] ef, ewe;
    @(posedge clk);
    #1;
    src = s_; dst = d_; size = sz_; op = o_; x = x_; z = z_; areg = a_;
    @(negedge clk);
    model(er, ef, ewe);
    chk(a_ ? "R10" : "R1", "res upper", longint'(res), longint'(er));
    chk(a_ ? "R10" : "R11", "ccr_we", longint'(we), longint'(ewe));
    if (!a_) begin
      chk(o_[2] ? "R3" : "R2", "C", longint'(ccr[0]), longint'(ef[0]));
      chk("R4", "V", longint'(ccr[1]), longint'(ef[1]));
      chk(o_[1:0] == 2'b11 ? "R8" : "R5", "Z", longint'(ccr[2]), longint'(ef[2]));
      chk("R5", "N", longint'(ccr[3]), longint'(ef[3]));
      chk("R6", "X", longint'(ccr[4]), longint'(ef[4]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    src = '0; dst = '0; size = '0; op = '0; x = 0; z = 0; areg = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5", "idle res", longint'(res), 0);
    chk("R11", "idle we", longint'(we), 32'h1F);
    chk("R5", "idle ccr", longint'(ccr), 32'h04);
    // R2 R4 R6: byte 90+107
    apply(32'd107, 32'hAAAA_AA5A, 2'b00, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R2", "byte add res", longint'(res[7:0]), 32'hC5);
    chk("R4", "byte add ccr", longint'(ccr), 32'h0A);
    // R3 R6: byte 90-107
    apply(32'd107, 32'h0000_005A, 2'b00, 3'b100, 1'b0, 1'b0, 1'b0);
    chk("R3", "byte sub res", longint'(res), 32'hEF);
    chk("R6", "byte sub ccr", longint'(ccr), 32'h19);
    // R9: quick 000 = 8, upper src ignored
    apply(32'hFFFF_FFF8, 32'd10, 2'b10, 3'b010, 1'b0, 1'b0, 1'b0);
    chk("R9", "quick 8", longint'(res), 18);
    apply(32'h0000_0005, 32'h0000_FFFF, 2'b01, 3'b110, 1'b1, 1'b1, 1'b0);
    chk("R9", "quick sub 5", longint'(res), 32'hFFFA);
    // R7 R8: extended corners
    for (int sz = 0; sz < 3; sz++) begin
      for (int zz = 0; zz < 2; zz++) begin
        apply(32'h1234_5678, 32'h1234_5678, 2'(sz), 3'b111, 1'b0, zz[0], 1'b0);
        chk("R8", "subx eq z", longint'(ccr[2]), longint'(zz));
        apply(32'h1234_5678, 32'h1234_5678, 2'(sz), 3'b111, 1'b1, zz[0], 1'b0);
        chk("R7", "subx borrow", longint'(ccr[0]), 1);
        apply(32'hFFFF_FFFF, 32'h0000_0000, 2'(sz), 3'b011, 1'b1, zz[0], 1'b0);
        chk("R8", "addx wrap z", longint'(ccr[2]), longint'(zz));
      end
    end
    // R10: address destination
    apply(32'h0000_8000, 32'h0001_0000, 2'b01, 3'b000, 1'b1, 1'b0, 1'b1);
    chk("R10", "areg sext", longint'(res), 32'h0000_8000);
    apply(32'h0000_0000, 32'h0000_0010, 2'b10, 3'b110, 1'b1, 1'b0, 1'b1);
    chk("R10", "areg quick", longint'(res), 32'h0000_0008);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] o;
      o = 3'($urandom);
      if (o[1:0] == 2'b10) o[1:0] = 2'b01;
      if (i % 4 == 0) o[1:0] = 2'b10;
      apply($urandom, (i % 7 == 0) ? 32'h0 : $urandom, 2'($urandom), o,
            1'($urandom), 1'($urandom), (i % 9 == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule